// File: doc/BRIEF.md
# Multidrop Address Wake/Doze Controller

This block sits between a 9-bit multidrop UART receiver and its receive FIFO. Each incoming character arrives with an address/data flag (A/D) and its error flags. The block decides whether the character is written into the FIFO. It also forms the status word that goes with the character. The receiver enable state and the address configuration drive that decision.

Besides the usual CPU-driven wake-up, two automatic modes exist. In auto-wake, an address character equal to a programmable match byte turns the receiver on. In auto-doze, an address character that differs from the match byte turns it off. No host action is needed for either change. Every address event in an automatic mode latches a pending flag, which drives a maskable interrupt. The host clears that flag with a strobe or a receiver reset.

Top module: `mdrop_wake_ctrl`

## Requirements
- R1: While the receiver is disabled, a data character (A/D = 0) that carries no break flag is not pushed.
- R2: While the receiver is enabled, every data character is pushed. The push appears one cycle after `rx_valid`, and `fifo_data` holds the received byte.
- R3: The status word of a pushed character follows this layout: bit 5 is the A/D flag, bit 6 is framing error, bit 4 is overrun and bit 7 is break. All other bits are 0.
- R4: A character with the break flag set is pushed whether the receiver is enabled or not.
- R5: With the wake mode field at 00, an address character is always pushed. With either automatic bit set, an address character is pushed only when `cfg_keep_addr` is 1.
- R6: After reset, `rx_enabled`, `fifo_push` and `irq` are 0. In mode 00, address characters leave the enable state unchanged.
- R7: With wake mode bit 0 set, an address character equal to `cfg_match` sets `rx_enabled` on the next cycle.
- R8: With wake mode bit 1 set, an address character different from `cfg_match` clears `rx_enabled` on the next cycle.
- R9: An address character received while either automatic bit is set latches the pending flag on the next cycle. `irq` equals the pending flag ANDed with `cfg_irq_en`. If a new event and a clear fall on the same cycle, the flag stays set.
- R10: `cmd_irq_clr` clears the pending flag. `cmd_rx_reset` clears the pending flag and disables the receiver.
- R11: `cmd_rx_en` and `cmd_rx_dis` take effect on the next cycle. A CPU command wins over an automatic change in the same cycle, and disable wins over enable. `cmd_rx_en` is ignored while the pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received byte |
| rx_ad | input | 1 | Address/data flag, 1 = address |
| rx_ferr | input | 1 | Framing error flag |
| rx_ovr | input | 1 | Overrun flag |
| rx_brk | input | 1 | Break flag |
| cfg_wake_mode | input | 2 | Bit 0 enables auto-wake, bit 1 enables auto-doze |
| cfg_keep_addr | input | 1 | In automatic modes, push address characters (1) or strip them (0) |
| cfg_match | input | 8 | Address match byte |
| cfg_irq_en | input | 1 | Interrupt enable for address events |
| cmd_rx_en | input | 1 | CPU receiver-enable strobe |
| cmd_rx_dis | input | 1 | CPU receiver-disable strobe |
| cmd_irq_clr | input | 1 | Clears the pending address flag |
| cmd_rx_reset | input | 1 | Receiver reset: clears the pending flag and disables the receiver |
| fifo_push | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Byte to write |
| fifo_stat | output | 8 | Status word to write |
| rx_enabled | output | 1 | Receiver enable state |
| irq | output | 1 | Address-recognition interrupt, active high |

## Verification
The bench builds the block with its defaults: an 8-bit data path, an 8-bit status word, and the A/D flag at status bit 5. With these values, fixed bytes like 0x5A and 0x33 serve as matching and non-matching addresses. Every status bit can be checked by its position. The directed scenarios place address characters and CPU strobes on the same cycle, so the tie rules can be observed: CPU over automatic, event over clear, and the blocked enable.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  typedef struct packed {
    logic doze;
    logic wake;
  } wake_mode_t;

  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_STAT_W  = 8;
  localparam int unsigned DEF_OVR_POS = 4;
  localparam int unsigned DEF_AD_POS  = 5;
  localparam int unsigned DEF_FE_POS  = 6;
  localparam int unsigned DEF_BRK_POS = 7;
endpackage

// File: rtl/mdw_push_filter.sv
module mdw_push_filter
  import mdw_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic              ad,
  input  logic              brk,
  input  logic              en,
  input  wake_mode_t        mode,
  input  logic              keep_addr,
  input  logic [DATA_W-1:0] match_val,
  output logic              push,
  output logic              addr_evt,
  output logic              hit
);
  logic auto_on;

  always_comb begin
    auto_on  = mode.wake | mode.doze;
    hit      = (data == match_val);
    addr_evt = valid & ad & auto_on;
    push     = 1'b0;
    if (valid) begin
      if (brk)        push = 1'b1;
      else if (ad)    push = auto_on ? keep_addr : 1'b1;
      else            push = en;
    end
  end
endmodule

// File: rtl/mdw_enable_ctrl.sv
module mdw_enable_ctrl
  import mdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_evt,
  input  logic       hit,
  input  wake_mode_t mode,
  input  logic       cmd_en,
  input  logic       cmd_dis,
  input  logic       cmd_rst,
  input  logic       pend,
  output logic       en_q
);
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (addr_evt) begin
      if (mode.wake && hit)  en_d = 1'b1;
      if (mode.doze && !hit) en_d = 1'b0;
    end
    if (cmd_rst || cmd_dis)  en_d = 1'b0;
    else if (cmd_en && !pend) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/mdw_irq_pend.sv
module mdw_irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_evt,
  input  logic clr,
  output logic pend_q
);
  logic pend_d;
  logic pend_ce;

  always_comb begin
    pend_ce = addr_evt | clr;
    pend_d  = addr_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end
endmodule

// File: rtl/mdrop_wake_ctrl.sv
module mdrop_wake_ctrl
  import mdw_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned STAT_W  = DEF_STAT_W,
  parameter int unsigned OVR_POS = DEF_OVR_POS,
  parameter int unsigned AD_POS  = DEF_AD_POS,
  parameter int unsigned FE_POS  = DEF_FE_POS,
  parameter int unsigned BRK_POS = DEF_BRK_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ad,
  input  logic              rx_ferr,
  input  logic              rx_ovr,
  input  logic              rx_brk,
  input  logic [1:0]        cfg_wake_mode,
  input  logic              cfg_keep_addr,
  input  logic [DATA_W-1:0] cfg_match,
  input  logic              cfg_irq_en,
  input  logic              cmd_rx_en,
  input  logic              cmd_rx_dis,
  input  logic              cmd_irq_clr,
  input  logic              cmd_rx_reset,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data,
  output logic [STAT_W-1:0] fifo_stat,
  output logic              rx_enabled,
  output logic              irq
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  wake_mode_t             mode;
  logic                   push_d;
  logic                   addr_evt;
  logic                   hit;
  logic                   pend_q;
  logic [STAT_W-1:0]      stat_d;

  // reset asserts at once, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  assign mode = wake_mode_t'(cfg_wake_mode);

  mdw_push_filter #(.DATA_W(DATA_W)) u_filter (
    .valid     (rx_valid),
    .data      (rx_data),
    .ad        (rx_ad),
    .brk       (rx_brk),
    .en        (rx_enabled),
    .mode      (mode),
    .keep_addr (cfg_keep_addr),
    .match_val (cfg_match),
    .push      (push_d),
    .addr_evt  (addr_evt),
    .hit       (hit)
  );

  mdw_enable_ctrl u_enable (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_evt (addr_evt),
    .hit      (hit),
    .mode     (mode),
    .cmd_en   (cmd_rx_en),
    .cmd_dis  (cmd_rx_dis),
    .cmd_rst  (cmd_rx_reset),
    .pend     (pend_q),
    .en_q     (rx_enabled)
  );

  mdw_irq_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_evt (addr_evt),
    .clr      (cmd_irq_clr | cmd_rx_reset),
    .pend_q   (pend_q)
  );

  always_comb begin
    stat_d          = '0;
    stat_d[OVR_POS] = rx_ovr;
    stat_d[AD_POS]  = rx_ad;
    stat_d[FE_POS]  = rx_ferr;
    stat_d[BRK_POS] = rx_brk;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fifo_push <= 1'b0;
    else             fifo_push <= push_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fifo_data <= '0;
      fifo_stat <= '0;
    end else if (push_d) begin
      fifo_data <= rx_data;
      fifo_stat <= stat_d;
    end
  end

  assign irq = pend_q & cfg_irq_en;
endmodule

// File: rtl/mdw_checker.sv
module mdw_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAT_W = 8,
  parameter int unsigned AD_POS = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ad,
  input logic              rx_brk,
  input logic [1:0]        cfg_wake_mode,
  input logic [DATA_W-1:0] cfg_match,
  input logic              cmd_rx_en,
  input logic              cmd_rx_dis,
  input logic              cmd_rx_reset,
  input logic              fifo_push,
  input logic [STAT_W-1:0] fifo_stat,
  input logic              rx_enabled,
  input logic              pend_q
);
  AST_DISABLED_DROPS_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && !rx_ad && !rx_brk && !rx_enabled) |=> !fifo_push); // R1

  AST_ENABLED_PUSHES_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && !rx_ad && rx_enabled) |=> fifo_push); // R2

  AST_AD_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |=> (!fifo_push || fifo_stat[AD_POS] == $past(rx_ad))); // R3

  AST_BREAK_PUSHED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_brk) |=> fifo_push); // R4

  AST_WAKE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_ad && cfg_wake_mode[0] && rx_data == cfg_match
     && !cmd_rx_dis && !cmd_rx_reset) |=> rx_enabled); // R7

  AST_DOZE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_ad && cfg_wake_mode[1] && rx_data != cfg_match
     && !cmd_rx_en) |=> !rx_enabled); // R8

  AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_ad && cfg_wake_mode != 2'b00) |=> pend_q); // R9

  AST_EN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_q && !rx_enabled && cmd_rx_en && !rx_valid) |=> !rx_enabled); // R11
endmodule

bind mdrop_wake_ctrl mdw_checker #(
  .DATA_W (DATA_W),
  .STAT_W (STAT_W),
  .AD_POS (AD_POS)
) u_mdw_checker (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .rx_valid      (rx_valid),
  .rx_data       (rx_data),
  .rx_ad         (rx_ad),
  .rx_brk        (rx_brk),
  .cfg_wake_mode (cfg_wake_mode),
  .cfg_match     (cfg_match),
  .cmd_rx_en     (cmd_rx_en),
  .cmd_rx_dis    (cmd_rx_dis),
  .cmd_rx_reset  (cmd_rx_reset),
  .fifo_push     (fifo_push),
  .fifo_stat     (fifo_stat),
  .rx_enabled    (rx_enabled),
  .pend_q        (pend_q)
);

// File: tb/test_mdrop_wake_ctrl.sv
module test_mdrop_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_ad, rx_ferr, rx_ovr, rx_brk;
  logic [7:0] rx_data;
  logic [1:0] cfg_wake_mode;
  logic       cfg_keep_addr, cfg_irq_en;
  logic [7:0] cfg_match;
  logic       cmd_rx_en, cmd_rx_dis, cmd_irq_clr, cmd_rx_reset;
  logic       fifo_push, rx_enabled, irq;
  logic [7:0] fifo_data, fifo_stat;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mdrop_wake_ctrl i_mdrop_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ad(rx_ad), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .rx_brk(rx_brk),
    .cfg_wake_mode(cfg_wake_mode), .cfg_keep_addr(cfg_keep_addr),
    .cfg_match(cfg_match), .cfg_irq_en(cfg_irq_en),
    .cmd_rx_en(cmd_rx_en), .cmd_rx_dis(cmd_rx_dis),
    .cmd_irq_clr(cmd_irq_clr), .cmd_rx_reset(cmd_rx_reset),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .fifo_stat(fifo_stat),
    .rx_enabled(rx_enabled), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at a negedge, return at the next negedge
  task automatic cyc(input logic v, input logic [7:0] d, input logic ad,
                     input logic fe, input logic ov, input logic bk,
                     input logic en, input logic dis, input logic clr, input logic rr);
    rx_valid = v; rx_data = d; rx_ad = ad; rx_ferr = fe; rx_ovr = ov; rx_brk = bk;
    cmd_rx_en = en; cmd_rx_dis = dis; cmd_irq_clr = clr; cmd_rx_reset = rr;
    @(negedge clk);
    rx_valid = 0; rx_ad = 0; rx_ferr = 0; rx_ovr = 0; rx_brk = 0;
    cmd_rx_en = 0; cmd_rx_dis = 0; cmd_irq_clr = 0; cmd_rx_reset = 0;
  endtask

  task automatic t_reset();
    chk("R6 push after reset", {7'd0, fifo_push}, 8'd0);
    chk("R6 enable after reset", {7'd0, rx_enabled}, 8'd0);
    chk("R6 irq after reset", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_cpu_mode();
    cfg_wake_mode = 2'b00; cfg_irq_en = 1;
    cyc(1, 8'h41, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 data dropped while off", {7'd0, fifo_push}, 8'd0);
    cyc(1, 8'h77, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 address pushed in mode 00", {7'd0, fifo_push}, 8'd1);
    chk("R3 address status", fifo_stat, 8'h20);
    chk("R6 mode 00 no enable change", {7'd0, rx_enabled}, 8'd0);
    chk("R9 mode 00 no event", {7'd0, irq}, 8'd0);
    cyc(1, 8'h00, 0, 1, 0, 1, 0, 0, 0, 0);
    chk("R4 break pushed while off", {7'd0, fifo_push}, 8'd1);
    chk("R3 break status", fifo_stat, 8'hC0);
  endtask

  task automatic t_cpu_enable();
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R11 cpu enable", {7'd0, rx_enabled}, 8'd1);
    cyc(1, 8'hA5, 0, 1, 1, 0, 0, 0, 0, 0);
    chk("R2 data pushed while on", {7'd0, fifo_push}, 8'd1);
    chk("R2 data byte", fifo_data, 8'hA5);
    chk("R3 error status", fifo_stat, 8'h50);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R11 disable beats enable", {7'd0, rx_enabled}, 8'd0);
  endtask

  task automatic t_auto_wake();
    cfg_wake_mode = 2'b01; cfg_keep_addr = 0; cfg_match = 8'h5A;
    cyc(1, 8'h33, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 address stripped", {7'd0, fifo_push}, 8'd0);
    chk("R7 miss stays off", {7'd0, rx_enabled}, 8'd0);
    chk("R9 event pends", {7'd0, irq}, 8'd1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R10 clear strobe", {7'd0, irq}, 8'd0);
    cyc(1, 8'h5A, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 match wakes", {7'd0, rx_enabled}, 8'd1);
    chk("R5 matched address stripped", {7'd0, fifo_push}, 8'd0);
    cyc(1, 8'h12, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 later data queued", {7'd0, fifo_push}, 8'd1);
  endtask

  task automatic t_blocked_enable();
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R11 cpu disable", {7'd0, rx_enabled}, 8'd0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R11 enable ignored while pending", {7'd0, rx_enabled}, 8'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R11 enable after clear", {7'd0, rx_enabled}, 8'd1);
  endtask

  task automatic t_auto_doze();
    cfg_wake_mode = 2'b10; cfg_keep_addr = 1;
    cyc(1, 8'h11, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 miss dozes", {7'd0, rx_enabled}, 8'd0);
    chk("R5 address kept", {7'd0, fifo_push}, 8'd1);
    cfg_irq_en = 0; #1;
    chk("R9 masked irq", {7'd0, irq}, 8'd0);
    cfg_irq_en = 1; #1;
    chk("R9 unmasked irq", {7'd0, irq}, 8'd1);
    @(negedge clk);
    cyc(1, 8'h11, 1, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 event beats clear", {7'd0, irq}, 8'd1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 receiver reset clears", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_cpu_wins();
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R11 enable setup", {7'd0, rx_enabled}, 8'd1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 receiver reset disables", {7'd0, rx_enabled}, 8'd0);
    cfg_wake_mode = 2'b01;
    cyc(1, 8'h5A, 1, 0, 0, 0, 0, 1, 0, 0);
    chk("R11 cpu disable beats wake", {7'd0, rx_enabled}, 8'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cfg_wake_mode = 2'b10;
    cyc(1, 8'h99, 1, 0, 0, 0, 1, 0, 0, 0);
    chk("R11 cpu enable beats doze", {7'd0, rx_enabled}, 8'd1);
  endtask

  initial begin
    fork
      begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
      begin
        rst_n = 0;
        rx_valid = 0; rx_data = 0; rx_ad = 0; rx_ferr = 0; rx_ovr = 0; rx_brk = 0;
        cfg_wake_mode = 0; cfg_keep_addr = 0; cfg_match = 0; cfg_irq_en = 0;
        cmd_rx_en = 0; cmd_rx_dis = 0; cmd_irq_clr = 0; cmd_rx_reset = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        t_reset();
        t_cpu_mode();
        t_cpu_enable();
        t_auto_wake();
        t_blocked_enable();
        t_auto_doze();
        t_cpu_wins();
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule